// File: doc/BRIEF.md
# Dual-Channel Frame Sync Divider with Bypass

This block produces two independent frame sync outputs, channel A and channel B. Each channel has its own reference clock enable, external input line and divisor. Both channels share one 32-bit control word: the lower half belongs to channel A and the upper half to channel B. With a divisor of two or more, a channel counts enabled clock cycles. It emits a periodic frame sync whose period is the divisor and whose high time is taken from its half of the control word. A zero high time selects a half-period default. An oversized high time is limited so that every period still ends low.

A divisor of zero or one switches the channel into bypass. In bypass the counter is idle and only the two lowest bits of the channel's half-word matter. One bit selects inversion of the external input. The other bit selects between passing the (optionally inverted) input straight through and emitting a one-enable-wide strobe on each of its rising edges. All state advances only on cycles where the channel's enable is high. New divisor and width values are adopted at period boundaries.

Top module: `fsd_pair`

## Requirements
- R1: While reset is asserted, both frame sync outputs are low, and the first enabled cycle after reset starts a fresh period at count zero.
- R2: With divisor D ≥ 2 and width field W in 1..D-1, the output is high for the first W enabled cycles of every D-cycle period and low for the rest. The output of the k-th enabled cycle of a period (k from 0) is high exactly when k < W.
- R3: With divisor D ≥ 2 and a width field of zero, the high time is D/2 rounded down: D/2 for even D and (D-1)/2 for odd D.
- R4: With divisor D ≥ 2 and a width field ≥ D, the high time is D-1.
- R5: With divisor 0 or 1 and strobe bit clear, each enabled cycle drives the output to the external input XOR the invert bit. Channel A uses bit 0 (strobe) and bit 1 (invert); channel B uses bit 16 (strobe) and bit 17 (invert).
- R6: With divisor 0 or 1 and strobe bit set, the output goes high for one enabled cycle when the inverted-as-selected input is high now but was low on the previous enabled cycle. Otherwise the output is low.
- R7: A new divisor, width or mode is adopted only on the enabled cycle that follows the last cycle of the current period. In bypass, this happens on every enabled cycle.
- R8: In bypass, bits 15:2 (channel A) and 31:18 (channel B) of the control word have no effect on the output.
- R9: On a cycle with the channel's enable low, that channel's output and count do not change.
- R10: The channels are independent. Channel A's width field is bits 15:0 and channel B's is bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_a | input | 1 | Reference clock enable, channel A |
| tick_b | input | 1 | Reference clock enable, channel B |
| ext_a | input | 1 | External input line, channel A |
| ext_b | input | 1 | External input line, channel B |
| div_a | input | DIV_W | Divisor, channel A |
| div_b | input | DIV_W | Divisor, channel B |
| pw_word | input | PW_W | Shared width / bypass control word |
| fs_a | output | 1 | Frame sync, channel A |
| fs_b | output | 1 | Frame sync, channel B |

## Verification
A corrupted count or latched divisor shows up within one period as a frame sync whose rising edges are spaced wrongly or whose high time differs from the computed width. The sweep over small divisors and all width classes therefore exposes it in at most two periods per configuration. A wrong bypass decode appears on the very next enabled cycle as an output that disagrees with the input XOR invert, or as a strobe that lasts two cycles or fires on a falling edge. A boundary mistake shows up in the mid-period change test as a period that is cut short.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    typedef enum logic {
        MODE_DIV = 1'b0,
        MODE_BYP = 1'b1
    } mode_e;

    // control bit positions inside one channel's half-word (bypass only)
    localparam int STB_BIT = 0;
    localparam int INV_BIT = 1;
endpackage

// File: rtl/fsd_width.sv
module fsd_width #(
    parameter int DIV_W = 16,
    parameter int PW_W  = 16,
    localparam int CW   = (DIV_W > PW_W) ? DIV_W : PW_W
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [PW_W-1:0]  pw_i,
    output logic [CW-1:0]    wid_o
);
    logic [CW-1:0] d_ext;
    logic [CW-1:0] p_ext;

    always_comb begin
        d_ext = CW'(div_i);
        p_ext = CW'(pw_i);
        if (p_ext == '0)
            wid_o = d_ext >> 1;
        else if (p_ext >= d_ext)
            wid_o = d_ext - 1'b1;
        else
            wid_o = p_ext;
    end
endmodule

// File: rtl/fsd_chan.sv
module fsd_chan
    import fsd_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int PW_W  = 16,
    localparam int CW   = (DIV_W > PW_W) ? DIV_W : PW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ext,
    input  logic [DIV_W-1:0] div_in,
    input  logic [PW_W-1:0]  pw_in,
    output logic             fs
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic [CW-1:0]    wid;
        mode_e            mode;
        logic             prev;
        logic             fs;
    } chan_st_t;

    chan_st_t s_q, s_d;
    logic [CW-1:0] wid_new;
    logic stb_sel, inv_sel, lvl, at_edge;

    fsd_width #(.DIV_W(DIV_W), .PW_W(PW_W)) width_i (
        .div_i (div_in),
        .pw_i  (pw_in),
        .wid_o (wid_new)
    );

    assign stb_sel = pw_in[STB_BIT];
    assign inv_sel = pw_in[INV_BIT];
    assign lvl     = ext ^ inv_sel;
    assign at_edge = (s_q.mode == MODE_BYP) || (s_q.cnt == s_q.div - 1'b1);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.prev = lvl;
            if (at_edge) begin
                s_d.cnt  = '0;
                s_d.div  = div_in;
                s_d.wid  = wid_new;
                s_d.mode = (div_in < DIV_W'(2)) ? MODE_BYP : MODE_DIV;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            if (s_d.mode == MODE_BYP)
                s_d.fs = stb_sel ? (lvl & ~s_q.prev) : lvl;
            else
                s_d.fs = (CW'(s_d.cnt) < s_d.wid);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.div  <= '0;
            s_q.wid  <= '0;
            s_q.mode <= MODE_BYP;
            s_q.prev <= 1'b0;
            s_q.fs   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fs = s_q.fs;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_DIV) |-> (s_q.cnt < s_q.div));

    // R4
    wid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_DIV) |-> (s_q.wid != '0 && s_q.wid < CW'(s_q.div)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(s_q.fs) && $stable(s_q.cnt)));

    // R7
    boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.mode == MODE_DIV && !at_edge) |=> ($stable(s_q.div) && $stable(s_q.wid)));

    // R6
    strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.mode == MODE_BYP && stb_sel && s_q.fs && s_d.mode == MODE_BYP) |=> !s_q.fs);
endmodule

// File: rtl/fsd_pair.sv
module fsd_pair #(
    parameter int DIV_W = 16,
    parameter int PW_W  = 32,
    localparam int HALF = PW_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             ext_a,
    input  logic             ext_b,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    input  logic [PW_W-1:0]  pw_word,
    output logic             fs_a,
    output logic             fs_b
);
    localparam int NCH = 2;

    logic [NCH-1:0]            tick_v, ext_v, fs_v;
    logic [NCH-1:0][DIV_W-1:0] div_v;

    assign tick_v = {tick_b, tick_a};
    assign ext_v  = {ext_b, ext_a};
    assign div_v  = {div_b, div_a};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        fsd_chan #(.DIV_W(DIV_W), .PW_W(HALF)) chan_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_v[ch]),
            .ext    (ext_v[ch]),
            .div_in (div_v[ch]),
            .pw_in  (pw_word[ch*HALF +: HALF]),
            .fs     (fs_v[ch])
        );
    end

    assign fs_a = fs_v[0];
    assign fs_b = fs_v[1];
endmodule

// File: tb/fsd_pair_tb.sv
module fsd_pair_tb_top;
    localparam int DIV_W = 16;
    localparam int PW_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_a = 1'b0, tick_b = 1'b0, ext_a = 1'b0, ext_b = 1'b0;
    logic [DIV_W-1:0] div_a = '0, div_b = '0;
    logic [PW_W-1:0]  pw_word = '0;
    logic fs_a, fs_b;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    fsd_pair #(.DIV_W(DIV_W), .PW_W(PW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .ext_a(ext_a), .ext_b(ext_b), .div_a(div_a), .div_b(div_b),
        .pw_word(pw_word), .fs_a(fs_a), .fs_b(fs_b)
    );

    function automatic int exp_w(int d, int p);
        if (p == 0) return d / 2;
        if (p >= d) return d - 1;
        return p;
    endfunction

    task automatic check(input logic got, input logic expv, input string req);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, expv, $time);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // R1: hold reset, check outputs low, release at a negedge
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(fs_a, 1'b0, "R1 fs_a in reset");
        check(fs_b, 1'b0, "R1 fs_b in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R2 R3 R4 R10: sweep of divisors and width classes
        for (int d = 2; d <= 9; d++) begin
            for (int p = 0; p <= 11; p++) begin
                int db, pb;
                string ra;
                db = d + 1;
                pb = (p + 3) % 12;
                ra = (p == 0) ? "R3" : ((p >= d) ? "R4" : "R2");
                tick_a = 1'b1; tick_b = 1'b1;
                div_a = DIV_W'(d); div_b = DIV_W'(db);
                pw_word = {16'(pb), 16'(p)};
                do_reset();
                for (int k = 0; k < 20; k++) begin
                    @(posedge clk);
                    @(negedge clk);
                    check(fs_a, (k % d) < exp_w(d, p), ra);
                    check(fs_b, (k % db) < exp_w(db, pb), "R10 channel B");
                end
            end
        end

        // R9: sparse enable on channel A
        begin
            int n;
            n = 0;
            div_a = 16'd5; pw_word = {16'd0, 16'd2};
            tick_a = 1'b0;
            do_reset();
            for (int c = 0; c < 40; c++) begin
                tick_a = (c % 3) != 0;
                if (tick_a) n++;
                @(posedge clk);
                @(negedge clk);
                check(fs_a, (n == 0) ? 1'b0 : (((n - 1) % 5) < 2), "R9 gated enable");
            end
        end

        // R7: mid-period change waits for the boundary
        tick_a = 1'b1; div_a = 16'd6; pw_word = {16'd0, 16'd3}; ext_a = 1'b0;
        do_reset();
        for (int k = 0; k < 11; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k < 6)
                check(fs_a, k < 3, "R7 old period kept");
            else if (k < 9)
                check(fs_a, ((k - 6) % 3) < 1, "R7 new period");
            else
                check(fs_a, 1'b1, "R7 bypass at boundary");
            if (k == 1) begin
                div_a = 16'd3; pw_word = {16'd0, 16'd1};
            end
            if (k == 7) begin
                div_a = 16'd0; pw_word = '0; ext_a = 1'b1;
            end
        end
        // k==8 above: still old period of 3 (cnt=2), checked as (2%3)<1 = 0

        // R5 R6 R8: bypass combinations on both channels
        for (int dv = 0; dv <= 1; dv++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int g = 0; g <= 1; g++) begin
                    logic stb, inv, pa, pb2, la, lb;
                    string rq;
                    stb = mode[0]; inv = mode[1];
                    rq = (g == 1) ? "R8 ignored bits" : (stb ? "R6 strobe" : "R5 pass");
                    div_a = DIV_W'(dv); div_b = DIV_W'(1 - dv);
                    tick_a = 1'b1; tick_b = 1'b1;
                    pw_word = {14'd0, inv, stb, 14'd0, inv, stb};
                    ext_a = 1'b0; ext_b = 1'b0;
                    do_reset();
                    pa = 1'b0; pb2 = 1'b0;
                    for (int c = 0; c < 40; c++) begin
                        next_rand();
                        ext_a = lfsr[0]; ext_b = lfsr[3];
                        if (g == 1)
                            pw_word = {lfsr[13:0], inv, stb, lfsr[15:2], inv, stb};
                        la = ext_a ^ inv; lb = ext_b ^ inv;
                        @(posedge clk);
                        @(negedge clk);
                        check(fs_a, stb ? (la & ~pa) : la, rq);
                        check(fs_b, stb ? (lb & ~pb2) : lb, rq);
                        pa = la; pb2 = lb;
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule